// File: doc/BRIEF.md
# Reorder Buffer with Operand Capture and Result Wakeup

This block is the instruction window of a small, non-speculative out-of-order core that runs only two-source, one-destination arithmetic and logic operations. Each instruction is written at the tail of a circular buffer, and its slot index becomes its tag. For each source it captures a value at dispatch: from the register file lookup if the register holds a committed value, or from a producer entry that has finished or is finishing in that same cycle. Otherwise it records the producer's tag and waits.

Every cycle in which the shared execution slot is granted, the oldest entry that has both operands and has not yet run passes through a combinational ALU. Its result is written into the entry and broadcast by tag, so any waiting operand with a matching tag captures the value. Finished instructions leave in program order from the head. Each one presents its destination register, tag and result to the register file, which writes the value only if that tag is still the latest writer of the register.

A drain input empties the buffer. While drain is high, dispatch is refused, and each cycle the head entry runs if it has not run yet and retires in that same cycle. A buffer holding k entries is therefore empty after k cycles.

Top module: `ooo_rob`

## Requirements
- R1: After reset the buffer is empty and all done bits are clear: `disp_ready` is 1 and `ret_valid` is 0.
- R2: A dispatch is accepted in a cycle with `disp_valid` and `disp_ready` both high. `disp_tag` is the slot written, and tags run 0, 1, 2, ... modulo DEPTH from reset. `disp_ready` is 0 while DEPTH entries are held.
- R3: A source whose lookup reports a valid register is stored ready with the looked-up value.
- R4: A source whose register is not valid takes its value from the entry named by the looked-up tag. It takes the stored result if that entry is already done, or the broadcast result if that entry executes in the same cycle. In both cases it is stored ready.
- R5: Any other source is stored not ready, together with the producer tag. It becomes ready with the value broadcast under that tag. An entry never executes before both sources are ready.
- R6: The ALU code is `disp_op`: 2'b00 gives src1+src2, 2'b01 gives src1-src2, 2'b10 gives src1 AND src2, and 2'b11 gives src1 XOR src2. All results wrap modulo 2^DATA_W.
- R7: An entry executes only in a cycle with `exec_grant` or `drain` high. At most one entry executes per cycle, and it is the oldest entry that is ready and not done. Its result and done bit are stored at the next clock edge.
- R8: When the head entry is done, `ret_valid` is 1 with that entry's `ret_dst`, `ret_tag` and `ret_value`, and the head advances by one at the edge. Retirement follows dispatch order.
- R9: While `drain` is high, `disp_ready` is 0, and a non-empty buffer retires its head every cycle. A head that has not run executes in that same cycle, and its result goes to `ret_value` and to the broadcast. k entries empty in k cycles.
- R10: A dispatch, an execution and a retirement can all take place in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_op | input | 2 | ALU operation code (R6) |
| disp_dst | input | REG_W | Destination register identifier |
| disp_ready | output | 1 | Buffer can accept a dispatch this cycle |
| disp_tag | output | log2(DEPTH) | Tag (slot index) given to the dispatched instruction |
| s1_rf_valid | input | 1 | First source register holds a committed value |
| s1_rf_value | input | DATA_W | First source register value |
| s1_rf_tag | input | log2(DEPTH) | Tag of the latest writer of the first source register |
| s2_rf_valid | input | 1 | Second source register holds a committed value |
| s2_rf_value | input | DATA_W | Second source register value |
| s2_rf_tag | input | log2(DEPTH) | Tag of the latest writer of the second source register |
| exec_grant | input | 1 | Execution slot available this cycle |
| drain | input | 1 | Force the head to complete and retire every cycle |
| ret_valid | output | 1 | Head instruction retires this cycle |
| ret_dst | output | REG_W | Destination register of the retiring instruction |
| ret_tag | output | log2(DEPTH) | Tag of the retiring instruction |
| ret_value | output | DATA_W | Result of the retiring instruction |

## Verification
The functions that can coincide are dispatch capture and the result broadcast. A dispatched source may name a producer that is finishing in the same cycle or one that finished a cycle before and is retiring. A back-to-back stream sets up both cases on purpose: a third instruction reads the destinations of the two instructions before it. A second coincidence puts drain-mode execution and retirement of the head in one cycle while a waiting dependent captures the broadcast. The results are judged at the retire port against a sequential golden register model, and the per-cycle `ret_valid` pattern shows which entry ran in which cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Operation codes of the embedded ALU (R6)
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_XOR = 2'b11
  } alu_op_e;

  localparam int SRC_N = 2;

endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int DEPTH = 4,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [TAG_W-1:0] head_idx,
  output logic [TAG_W-1:0] tail_idx,
  output logic [TAG_W:0]   count,
  output logic             full,
  output logic             empty
);

  logic [TAG_W:0] head_q, tail_q;

  function automatic logic [TAG_W:0] bump(input logic [TAG_W:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push) tail_q <= bump(tail_q);
      if (pop)  head_q <= bump(head_q);
    end
  end

  assign head_idx = head_q[TAG_W-1:0];
  assign tail_idx = tail_q[TAG_W-1:0];
  assign count    = tail_q - head_q;
  assign empty    = (head_q == tail_q);
  assign full     = (head_q[TAG_W] != tail_q[TAG_W]) && (head_idx == tail_idx);

  assert_no_push_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  assert_no_pop_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (TAG_W+1)'(DEPTH));

endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
  parameter int DEPTH = 4,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic [TAG_W-1:0] head_idx,
  input  logic [TAG_W:0]   count,
  input  logic [DEPTH-1:0] cand,
  input  logic             enable,
  output logic             fire,
  output logic [TAG_W-1:0] tag
);

  // slot holding the entry that is 'age' places younger than the head
  function automatic logic [TAG_W-1:0] slot_at(input logic [TAG_W-1:0] base,
                                               input int unsigned age);
    return base + age[TAG_W-1:0];
  endfunction

  always_comb begin
    fire = 1'b0;
    tag  = '0;
    for (int unsigned a = 0; a < DEPTH; a++) begin
      if (!fire && enable && (a < 32'(count)) && cand[slot_at(head_idx, a)]) begin
        fire = 1'b1;
        tag  = slot_at(head_idx, a);
      end
    end
  end

endmodule

// File: rtl/rob_src_cap.sv
module rob_src_cap #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 2
) (
  input  logic              rf_valid,
  input  logic [DATA_W-1:0] rf_value,
  input  logic [TAG_W-1:0]  rf_tag,
  input  logic              bc_fire,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  input  logic              prod_done,
  input  logic [DATA_W-1:0] prod_value,
  output logic              cap_ready,
  output logic [DATA_W-1:0] cap_value,
  output logic [TAG_W-1:0]  cap_tag
);

  always_comb begin
    cap_tag = rf_tag;
    if (rf_valid) begin
      cap_ready = 1'b1;
      cap_value = rf_value;
    end else if (bc_fire && (bc_tag == rf_tag)) begin
      cap_ready = 1'b1;
      cap_value = bc_value;
    end else if (prod_done) begin
      cap_ready = 1'b1;
      cap_value = prod_value;
    end else begin
      cap_ready = 1'b0;
      cap_value = '0;
    end
  end

endmodule

// File: rtl/rob_alu.sv
module rob_alu
  import rob_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  function automatic logic [DATA_W-1:0] alu_calc(input alu_op_e o,
                                                 input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] z);
    unique case (o)
      OP_ADD:  return x + z;
      OP_SUB:  return x - z;
      OP_AND:  return x & z;
      default: return x ^ z;
    endcase
  endfunction

  assign y = alu_calc(op, a, b);

endmodule

// File: rtl/ooo_rob.sv
module ooo_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int REG_W  = 3,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [1:0]        disp_op,
  input  logic [REG_W-1:0]  disp_dst,
  output logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              s1_rf_valid,
  input  logic [DATA_W-1:0] s1_rf_value,
  input  logic [TAG_W-1:0]  s1_rf_tag,
  input  logic              s2_rf_valid,
  input  logic [DATA_W-1:0] s2_rf_value,
  input  logic [TAG_W-1:0]  s2_rf_tag,
  input  logic              exec_grant,
  input  logic              drain,
  output logic              ret_valid,
  output logic [REG_W-1:0]  ret_dst,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [DATA_W-1:0] ret_value
);

  // ---------------- entry storage ----------------
  logic [DEPTH-1:0]  done_q;
  alu_op_e           op_q   [DEPTH];
  logic [REG_W-1:0]  dst_q  [DEPTH];
  logic [DATA_W-1:0] res_q  [DEPTH];
  logic [DATA_W-1:0] sval_q [SRC_N][DEPTH];
  logic [DEPTH-1:0]  srdy_q [SRC_N];
  logic [TAG_W-1:0]  stag_q [SRC_N][DEPTH];

  // ---------------- named internal events ----------------
  logic              disp_fire;
  logic              bc_fire;
  logic [TAG_W-1:0]  bc_tag;
  logic [DATA_W-1:0] bc_value;
  logic              head_done;
  logic              head_forced;
  logic [TAG_W-1:0]  head_idx, tail_idx;
  logic [TAG_W:0]    count;
  logic              full, empty;
  logic [DEPTH-1:0]  live;
  logic [DEPTH-1:0]  cand;

  // ---------------- pointers ----------------
  rob_ptr #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (disp_fire),
    .pop      (ret_valid),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .count    (count),
    .full     (full),
    .empty    (empty)
  );

  function automatic logic [TAG_W-1:0] age_of(input int unsigned slot,
                                              input logic [TAG_W-1:0] base);
    return TAG_W'(slot) - base;
  endfunction

  always_comb begin
    for (int unsigned i = 0; i < DEPTH; i++) begin
      live[i] = ({1'b0, age_of(i, head_idx)} < count);
      cand[i] = live[i] && !done_q[i] && srdy_q[0][i] && srdy_q[1][i];
    end
  end

  // ---------------- execute selection and ALU ----------------
  rob_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
    .head_idx (head_idx),
    .count    (count),
    .cand     (cand),
    .enable   (exec_grant || drain),
    .fire     (bc_fire),
    .tag      (bc_tag)
  );

  rob_alu #(.DATA_W(DATA_W)) u_alu (
    .op (op_q[bc_tag]),
    .a  (sval_q[0][bc_tag]),
    .b  (sval_q[1][bc_tag]),
    .y  (bc_value)
  );

  // ---------------- dispatch capture ----------------
  logic              rf_ok  [SRC_N];
  logic [DATA_W-1:0] rf_val [SRC_N];
  logic [TAG_W-1:0]  rf_tg  [SRC_N];
  logic              cap_ready [SRC_N];
  logic [DATA_W-1:0] cap_value [SRC_N];
  logic [TAG_W-1:0]  cap_tag   [SRC_N];

  assign rf_ok[0]  = s1_rf_valid;
  assign rf_val[0] = s1_rf_value;
  assign rf_tg[0]  = s1_rf_tag;
  assign rf_ok[1]  = s2_rf_valid;
  assign rf_val[1] = s2_rf_value;
  assign rf_tg[1]  = s2_rf_tag;

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    rob_src_cap #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cap (
      .rf_valid   (rf_ok[s]),
      .rf_value   (rf_val[s]),
      .rf_tag     (rf_tg[s]),
      .bc_fire    (bc_fire),
      .bc_tag     (bc_tag),
      .bc_value   (bc_value),
      .prod_done  (done_q[rf_tg[s]]),
      .prod_value (res_q[rf_tg[s]]),
      .cap_ready  (cap_ready[s]),
      .cap_value  (cap_value[s]),
      .cap_tag    (cap_tag[s])
    );
  end

  assign disp_ready = !full && !drain;
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_tag   = tail_idx;

  // ---------------- retire ----------------
  assign head_done   = done_q[head_idx];
  assign head_forced = drain && bc_fire && (bc_tag == head_idx);
  assign ret_valid   = !empty && (head_done || head_forced);
  assign ret_dst     = dst_q[head_idx];
  assign ret_tag     = head_idx;
  assign ret_value   = head_done ? res_q[head_idx] : bc_value;

  // ---------------- state update ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
    end else begin
      if (bc_fire)   done_q[bc_tag]   <= 1'b1;
      if (disp_fire) done_q[tail_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (bc_fire) res_q[bc_tag] <= bc_value;
    for (int s = 0; s < SRC_N; s++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (bc_fire && live[i] && !srdy_q[s][i] && (stag_q[s][i] == bc_tag)) begin
          sval_q[s][i] <= bc_value;
          srdy_q[s][i] <= 1'b1;
        end
      end
    end
    if (disp_fire) begin
      op_q[tail_idx]  <= alu_op_e'(disp_op);
      dst_q[tail_idx] <= disp_dst;
      for (int s = 0; s < SRC_N; s++) begin
        sval_q[s][tail_idx] <= cap_value[s];
        srdy_q[s][tail_idx] <= cap_ready[s];
        stag_q[s][tail_idx] <= cap_tag[s];
      end
    end
  end

  // ---------------- assertions ----------------
  assert_head_has_operands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> (srdy_q[0][head_idx] && srdy_q[1][head_idx]));

  assert_exec_target_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bc_fire |-> (srdy_q[0][bc_tag] && srdy_q[1][bc_tag] && !done_q[bc_tag] && live[bc_tag]));

  assert_exec_sets_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bc_fire |=> done_q[$past(bc_tag)]);

  assert_exec_needs_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bc_fire |-> (exec_grant || drain));

  assert_drain_retires_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !empty) |-> ret_valid);

  assert_drain_blocks_dispatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> !disp_fire);

  assert_retire_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !disp_fire) |=> (count == $past(count) - 1'b1));

  assert_dispatch_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && !ret_valid) |=> (count == $past(count) + 1'b1));

endmodule

// File: tb/ooo_rob_tb.sv
module ooo_rob_tb;

  localparam int DEPTH  = 4;
  localparam int DATA_W = 16;
  localparam int REG_W  = 3;
  localparam int TAG_W  = 2;
  localparam int NREG   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              disp_valid = 1'b0;
  logic [1:0]        disp_op = '0;
  logic [REG_W-1:0]  disp_dst = '0;
  logic              disp_ready;
  logic [TAG_W-1:0]  disp_tag;
  logic              s1_rf_valid = 1'b1;
  logic [DATA_W-1:0] s1_rf_value = '0;
  logic [TAG_W-1:0]  s1_rf_tag = '0;
  logic              s2_rf_valid = 1'b1;
  logic [DATA_W-1:0] s2_rf_value = '0;
  logic [TAG_W-1:0]  s2_rf_tag = '0;
  logic              exec_grant = 1'b1;
  logic              drain = 1'b0;
  logic              ret_valid;
  logic [REG_W-1:0]  ret_dst;
  logic [TAG_W-1:0]  ret_tag;
  logic [DATA_W-1:0] ret_value;

  always #5 clk = ~clk;

  ooo_rob #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_dut (.*);

  // ---------------- bench bookkeeping ----------------
  int n_checks = 0;
  int n_fail   = 0;

  // register file model seen by the block, and sequential golden model
  logic [DATA_W-1:0] mrf_val [NREG];
  logic              mrf_ok  [NREG];
  logic [TAG_W-1:0]  mrf_tag [NREG];
  logic [DATA_W-1:0] isa     [NREG];

  // expected retirements in program order
  int                eq_dst [256];
  int                eq_val [256];
  int                eq_tag [256];
  string             eq_req [256];
  int eq_wr = 0, eq_rd = 0;
  int next_tag = 0;

  bit want_grant = 1'b1;
  bit want_drain = 1'b0;
  bit last_acc, last_ret, last_ready;
  int overlap = 0;

  // stimulus table: {gap, op[1:0], src1[2:0], src2[2:0], dst[2:0]}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'd1, 3'd2, 3'd3},
    {1'b0, 2'd1, 3'd3, 3'd4, 3'd5},
    {1'b0, 2'd2, 3'd5, 3'd3, 3'd6},
    {1'b0, 2'd3, 3'd6, 3'd5, 3'd3},
    {1'b1, 2'd1, 3'd0, 3'd7, 3'd0},
    {1'b0, 2'd0, 3'd0, 3'd0, 3'd1},
    {1'b0, 2'd1, 3'd2, 3'd1, 3'd2},
    {1'b0, 2'd3, 3'd2, 3'd2, 3'd4},
    {1'b0, 2'd2, 3'd7, 3'd1, 3'd7},
    {1'b1, 2'd0, 3'd4, 3'd7, 3'd6}
  };

  function automatic int ref_alu(input int op, input int x, input int y);
    int r;
    case (op)
      0: r = x + y;
      1: r = x - y;
      2: r = x & y;
      default: r = x ^ y;
    endcase
    return r & 32'h0000_FFFF;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock cycle: drive at the falling edge, sample 1 ns later
  task automatic cycle(input bit v, input int op, input int s1, input int s2,
                       input int dst, input string req);
    @(negedge clk);
    exec_grant  = want_grant;
    drain       = want_drain;
    disp_valid  = v;
    disp_op     = op[1:0];
    disp_dst    = dst[REG_W-1:0];
    s1_rf_valid = mrf_ok[s1];
    s1_rf_value = mrf_val[s1];
    s1_rf_tag   = mrf_tag[s1];
    s2_rf_valid = mrf_ok[s2];
    s2_rf_value = mrf_val[s2];
    s2_rf_tag   = mrf_tag[s2];
    #1;
    last_ready = disp_ready;
    last_ret   = ret_valid;
    last_acc   = v && disp_ready;
    if (last_acc && ret_valid) overlap++;
    if (ret_valid) begin
      if (eq_rd == eq_wr) begin
        check(1'b0, "R8", "unexpected retire", 1, 0);
      end else begin
        check(ret_tag == TAG_W'(eq_tag[eq_rd]), "R8", "ret_tag", int'(ret_tag), eq_tag[eq_rd]);
        check(ret_dst == REG_W'(eq_dst[eq_rd]), "R8", "ret_dst", int'(ret_dst), eq_dst[eq_rd]);
        check(int'(ret_value) == eq_val[eq_rd], eq_req[eq_rd], "ret_value",
              int'(ret_value), eq_val[eq_rd]);
        eq_rd++;
      end
      if (!mrf_ok[ret_dst] && mrf_tag[ret_dst] == ret_tag) begin
        mrf_ok[ret_dst]  = 1'b1;
        mrf_val[ret_dst] = ret_value;
      end
    end
    if (last_acc) begin
      int g;
      check(disp_tag == TAG_W'(next_tag), "R2", "disp_tag", int'(disp_tag), next_tag);
      g = ref_alu(op, int'(isa[s1]), int'(isa[s2]));
      isa[dst] = DATA_W'(g);
      eq_dst[eq_wr] = dst;
      eq_val[eq_wr] = g;
      eq_tag[eq_wr] = next_tag;
      eq_req[eq_wr] = req;
      eq_wr++;
      mrf_ok[dst]  = 1'b0;
      mrf_tag[dst] = disp_tag;
      next_tag = (next_tag + 1) % DEPTH;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle(1'b0, 0, 0, 0, 0, "R8");
  endtask

  task automatic settle();
    for (int k = 0; k < 40 && eq_rd != eq_wr; k++) idle(1);
    check(eq_rd == eq_wr, "R8", "all retired", eq_rd, eq_wr);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R8 watchdog expired: actual 0 expected 1");
    report();
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin
      mrf_val[r] = DATA_W'(16'h1000 + r * 16'h0123);
      isa[r]     = mrf_val[r];
      mrf_ok[r]  = 1'b1;
      mrf_tag[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(disp_ready == 1'b1, "R1", "disp_ready after reset", int'(disp_ready), 1);
    check(ret_valid == 1'b0, "R1", "ret_valid after reset", int'(ret_valid), 0);

    // R3: all sources valid in the register file
    cycle(1'b1, 1, 5, 2, 4, "R3");
    settle();

    // R4: third instruction reads a done producer (r1) and a broadcasting one (r4)
    cycle(1'b1, 0, 2, 3, 1, "R6");
    cycle(1'b1, 3, 5, 6, 4, "R6");
    cycle(1'b1, 1, 1, 4, 7, "R4");
    settle();

    // table walk: back-to-back dependent stream, R6 / R10
    for (int v = 0; v < NV; v++) begin
      logic [11:0] e;
      e = VEC[v];
      do cycle(1'b1, int'(e[10:9]), int'(e[8:6]), int'(e[5:3]), int'(e[2:0]), "R6");
      while (!last_acc);
      if (e[11]) idle(1);
    end
    settle();
    check(overlap > 0, "R10", "dispatch and retire in one cycle", overlap, 1);

    // R5 / R7: hold the execution slot, build a waiting dependent
    want_grant = 1'b0;
    cycle(1'b1, 0, 1, 2, 0, "R6");
    cycle(1'b1, 2, 0, 1, 3, "R5");
    cycle(1'b1, 1, 6, 7, 5, "R6");
    idle(1);
    check(last_ret == 1'b0, "R7", "no execution without grant", int'(last_ret), 0);
    want_grant = 1'b1;
    idle(1);
    check(last_ret == 1'b0, "R7", "first grant cycle ret_valid", int'(last_ret), 0);
    for (int k = 0; k < 3; k++) begin
      idle(1);
      check(last_ret == 1'b1, "R7", "oldest-first retire stream", int'(last_ret), 1);
    end
    settle();

    // R2 / R9: fill the buffer with the slot held, then drain
    want_grant = 1'b0;
    cycle(1'b1, 0, 2, 3, 1, "R9");
    cycle(1'b1, 3, 1, 4, 2, "R9");
    cycle(1'b1, 1, 6, 2, 6, "R9");
    cycle(1'b1, 2, 7, 5, 3, "R9");
    cycle(1'b1, 0, 0, 0, 4, "R2");
    check(last_ready == 1'b0, "R2", "disp_ready when full", int'(last_ready), 0);
    check(last_acc == 1'b0, "R2", "dispatch refused when full", int'(last_acc), 0);
    want_drain = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      cycle(1'b1, 0, 0, 0, 4, "R9");
      check(last_ret == 1'b1, "R9", "drain retires every cycle", int'(last_ret), 1);
      check(last_ready == 1'b0, "R9", "disp_ready while draining", int'(last_ready), 0);
    end
    want_drain = 1'b0;
    want_grant = 1'b1;
    idle(1);
    check(last_ret == 1'b0, "R9", "empty after DEPTH drain cycles", int'(last_ret), 0);
    check(last_ready == 1'b1, "R9", "ready after drain", int'(last_ready), 1);
    check(eq_rd == eq_wr, "R9", "drained entries retired", eq_rd, eq_wr);

    report();
    $finish;
  end

endmodule